// File: doc/BRIEF.md
# Dual Capture/Match Timer Channel

This block is one timer channel that watches two free-running time bases, called A and B. It holds two capture slots and two match slots. A capture slot latches the value of its chosen time base when a qualifying edge appears on the filtered input pin. A match slot compares its stored value against its chosen time base. When a match fires it can raise a flag, drive the output pin, and latch the other time base into capture slot 2.

A single mode field turns the channel into one of several units:

- a capture unit;
- a capture unit with one or two match timeouts;
- a double-capture unit;
- a single or double output compare;
- an input-dependent output generator, where each captured edge drives the pin one clock later.

Configuration goes through a small write port. Writing a match value arms that match. Four sticky flags report events. A service-request line combines the flags that are enabled.

The input filter, the time-base counters, the sequencing engine and the host bus are outside the block. They appear only as plain ports.

Top module: `tmr_chan`

## Requirements
- R1: After reset, pin_out is 0, flags is 0000, srq is 0, both capture slots are 0, no match is armed, and the control word is 0 (mode 0, idle).
- R2: A write with cfg_sel=0 loads the control word, whose bits [2:0] hold the mode. Capture is active in modes 1, 2, 3, 4 and 7. Control bits [4:3] select the capture-1 edges: bit 3 enables rising edges and bit 4 enables falling edges. An edge is measured against the pin level at the previous clock. Control bit 11 selects the capture-1 base (0 = tb_a, 1 = tb_b). On a qualifying edge, cap1 takes that base's value at the same clock edge and flags[2] sets. Edges that are not enabled leave cap1 unchanged.
- R3: In mode 4, the first qualifying capture-1 edge loads cap1. The next edge that qualifies by control bits [6:5] (bit 5 rising, bit 6 falling) loads cap2 from the base chosen by control bit 12 and sets flags[3]. The two slots then alternate. A control-word write restarts the sequence at cap1.
- R4: A write with cfg_sel=1 loads match 1 and arms it; cfg_sel=2 does the same for match 2. Matches are compared only in these modes: match 1 in modes 2–6, match 2 in modes 3, 4 and 6. Control bits 9 and 10 select each match's base (0 = tb_a). In compare mode, a match fires when (base − value) mod 2^24 has its top bit clear. It fires once, sets flags[0] (match 1) or flags[1] (match 2), and stays disarmed until it is rewritten.
- R5: If control bit 7 (match 1) or bit 8 (match 2) is set, that match fires only when its base equals its value.
- R6: In modes 5 and 6, a firing match applies its 2-bit pin action: control bits [14:13] for match 1 and [16:15] for match 2. The codes are 00 keep, 01 high, 10 low, 11 toggle. If both matches fire on the same clock, only match 2's action is applied.
- R7: If control bit 23 is set, a firing match 1 also loads cap2 from the capture-2 base (control bit 12) and sets flags[3].
- R8: srq is high when any enabled flag is set. Control bit 19 enables flags[0] and bit 20 enables flags[1]. Bit 21 enables one capture flag, chosen by bit 22 (0 = flags[2], 1 = flags[3]).
- R9: Flags are sticky. A 1 on flag_clr[i] clears flags[i], but a new event on the same clock wins and leaves the flag set.
- R10: In mode 7, each qualifying capture-1 edge applies the action in control bits [18:17] to pin_out. The action uses the R6 coding and takes effect one clock after the capture is visible.
- R11: Outside the R6 and R10 cases pin_out holds its value. In modes 0, 1 and 7 an armed match never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Filtered input pin level |
| tb_a | input | 24 | Time base A |
| tb_b | input | 24 | Time base B |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 match 1, 2 match 2 |
| cfg_data | input | 24 | Write data |
| flag_clr | input | 4 | Per-flag clear strobes |
| pin_out | output | 1 | Output pin level |
| flags | output | 4 | Sticky flags: match 1, match 2, capture 1, capture 2 |
| srq | output | 1 | Service request |
| cap1 | output | 24 | Capture slot 1 |
| cap2 | output | 24 | Capture slot 2 |

## Verification
The internal state that can go wrong shows up at the ports in different ways and at different times:

- **Armed bits and capture phase.** A wrong armed bit shows up as a match flag that is missing or repeated on the first clock where the compare holds. A wrong capture phase shows up as the wrong slot updating on the next qualifying edge.
- **Pending input action.** A fault here moves or drops the pin change that should follow the capture by exactly one clock.
- **Comparator sign logic.** A fault appears only when the counters straddle a wrap. For that reason, directed cases place the match value just across the 2^24 boundary.

A cycle-by-cycle bench model compares every output on every clock, so a divergence is reported on the clock where it first shows.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [TW-1:0] tb_a,
  input  logic [TW-1:0] tb_b,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [TW-1:0] cfg_data,
  input  logic [3:0]    flag_clr,
  output logic          pin_out,
  output logic [3:0]    flags,
  output logic          srq,
  output logic [TW-1:0] cap1,
  output logic [TW-1:0] cap2
);
  localparam int CW = 24;

  logic [CW-1:0] ctl;
  logic [TW-1:0] mv1, mv2;
  logic          arm1, arm2, pin_q, ph, pend;

  wire [2:0] mode = ctl[2:0];
  wire use1 = (mode >= 3'd2) && (mode <= 3'd6);
  wire use2 = (mode == 3'd3) || (mode == 3'd4) || (mode == 3'd6);
  wire outm = (mode == 3'd5) || (mode == 3'd6);
  wire capm = (mode != 3'd0) && !outm;
  wire dbl  = (mode == 3'd4);
  wire idep = (mode == 3'd7);

  wire wr_ctl = cfg_we && (cfg_sel == 2'd0);
  wire wr_m1  = cfg_we && (cfg_sel == 2'd1);
  wire wr_m2  = cfg_we && (cfg_sel == 2'd2);

  wire [TW-1:0] base1 = ctl[9]  ? tb_b : tb_a;
  wire [TW-1:0] base2 = ctl[10] ? tb_b : tb_a;
  wire [TW-1:0] cb1   = ctl[11] ? tb_b : tb_a;
  wire [TW-1:0] cb2   = ctl[12] ? tb_b : tb_a;
  wire [TW-1:0] diff1 = base1 - mv1;
  wire [TW-1:0] diff2 = base2 - mv2;
  wire hit1 = ctl[7] ? (diff1 == '0) : !diff1[TW-1];
  wire hit2 = ctl[8] ? (diff2 == '0) : !diff2[TW-1];
  wire fire1 = arm1 && use1 && hit1;
  wire fire2 = arm2 && use2 && hit2;

  wire rise = pin_in && !pin_q;
  wire fall = !pin_in && pin_q;
  wire q1 = (ctl[3] && rise) || (ctl[4] && fall);
  wire q2 = (ctl[5] && rise) || (ctl[6] && fall);
  wire e1 = capm && q1 && !(dbl && ph);
  wire e2 = dbl && ph && q2;
  wire xcap = fire1 && ctl[23];

  function automatic logic act(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return !p;
      default: return p;
    endcase
  endfunction

  logic pin_nx;
  always_comb begin
    pin_nx = pin_out;
    if (pend)               pin_nx = act(ctl[18:17], pin_out);
    else if (outm && fire2) pin_nx = act(ctl[16:15], pin_out);
    else if (outm && fire1) pin_nx = act(ctl[14:13], pin_out);
  end

  assign srq = (flags[0] && ctl[19]) || (flags[1] && ctl[20]) ||
               (ctl[21] && (ctl[22] ? flags[3] : flags[2]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; mv1 <= '0; mv2 <= '0; arm1 <= 1'b0; arm2 <= 1'b0;
      pin_q <= 1'b0; ph <= 1'b0; pend <= 1'b0; pin_out <= 1'b0;
      flags <= '0; cap1 <= '0; cap2 <= '0;
    end else begin
      pin_q   <= pin_in;
      pin_out <= pin_nx;
      pend    <= idep && e1;
      flags   <= (flags & ~flag_clr) | {e2 || xcap, e1, fire2, fire1};
      if (e1)         cap1 <= cb1;
      if (e2 || xcap) cap2 <= cb2;
      if (wr_ctl) ctl <= cfg_data[CW-1:0];
      if (wr_m1) begin mv1 <= cfg_data; arm1 <= 1'b1; end
      else if (fire1) arm1 <= 1'b0;
      if (wr_m2) begin mv2 <= cfg_data; arm2 <= 1'b1; end
      else if (fire2) arm2 <= 1'b0;
      if (wr_ctl)        ph <= 1'b0;
      else if (e1 && dbl) ph <= 1'b1;
      else if (e2)       ph <= 1'b0;
    end
  end

  assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire1 && !wr_m1) |=> !arm1);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == 4'd0));
  assert_pin_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!outm && !pend) |=> $stable(pin_out));
  assert_srq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> (flags != 4'd0));
  assert_phase_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> !ph);
endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
  logic clk = 1'b0, rst_n = 1'b0, pin_in = 1'b0, cfg_we = 1'b0;
  logic [23:0] tb_a = '0, tb_b = '0, cfg_data = '0;
  logic [1:0] cfg_sel = '0;
  logic [3:0] flag_clr = '0;
  logic pin_out, srq;
  logic [3:0] flags;
  logic [23:0] cap1, cap2;
  int n_chk = 0, n_fail = 0;
  logic cmp_on = 1'b0;

  always #5 clk = !clk;

  tmr_chan u_tmr_chan (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tb_a(tb_a), .tb_b(tb_b),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .flag_clr(flag_clr),
    .pin_out(pin_out), .flags(flags), .srq(srq), .cap1(cap1), .cap2(cap2));

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic hit(input logic [23:0] t, input logic [23:0] m, input logic eqo);
    logic [23:0] d;
    d = t - m;
    return eqo ? (t == m) : (d[23] == 1'b0);
  endfunction

  function automatic logic pin_act(input logic [1:0] a, input logic p);
    case (a)
      2'b01: return 1'b1;
      2'b10: return 1'b0;
      2'b11: return !p;
      default: return p;
    endcase
  endfunction

  logic [23:0] r_ctl, r_m1, r_m2, r_c1, r_c2;
  logic r_a1, r_a2, r_q, r_ph, r_pend, r_pin;
  logic [3:0] r_fl;

  always @(posedge clk) begin : model
    logic [2:0] md;
    logic u1, u2, om, cm, f1, f2, rs, fl, e1, e2, xc, np;
    if (!rst_n) begin
      r_ctl = '0; r_m1 = '0; r_m2 = '0; r_c1 = '0; r_c2 = '0;
      r_a1 = 0; r_a2 = 0; r_q = 0; r_ph = 0; r_pend = 0; r_pin = 0; r_fl = '0;
    end else begin
      md = r_ctl[2:0];
      u1 = md inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
      u2 = md inside {3'd3, 3'd4, 3'd6};
      om = md inside {3'd5, 3'd6};
      cm = md inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
      f1 = r_a1 && u1 && hit(r_ctl[9] ? tb_b : tb_a, r_m1, r_ctl[7]);
      f2 = r_a2 && u2 && hit(r_ctl[10] ? tb_b : tb_a, r_m2, r_ctl[8]);
      rs = pin_in && !r_q;
      fl = !pin_in && r_q;
      e1 = cm && ((r_ctl[3] && rs) || (r_ctl[4] && fl)) && !(md == 3'd4 && r_ph);
      e2 = (md == 3'd4) && r_ph && ((r_ctl[5] && rs) || (r_ctl[6] && fl));
      xc = f1 && r_ctl[23];
      np = r_pin;
      if (r_pend) np = pin_act(r_ctl[18:17], r_pin);
      else if (om && f2) np = pin_act(r_ctl[16:15], r_pin);
      else if (om && f1) np = pin_act(r_ctl[14:13], r_pin);
      r_pin = np;
      r_pend = (md == 3'd7) && e1;
      r_fl = (r_fl & ~flag_clr) | {e2 || xc, e1, f2, f1};
      if (e1) r_c1 = r_ctl[11] ? tb_b : tb_a;
      if (e2 || xc) r_c2 = r_ctl[12] ? tb_b : tb_a;
      if (cfg_we && cfg_sel == 2'd0) r_ph = 0;
      else if (e1 && md == 3'd4) r_ph = 1;
      else if (e2) r_ph = 0;
      if (cfg_we && cfg_sel == 2'd1) begin r_m1 = cfg_data; r_a1 = 1; end
      else if (f1) r_a1 = 0;
      if (cfg_we && cfg_sel == 2'd2) begin r_m2 = cfg_data; r_a2 = 1; end
      else if (f2) r_a2 = 0;
      if (cfg_we && cfg_sel == 2'd0) r_ctl = cfg_data;
      r_q = pin_in;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R6 model pin_out", {23'd0, pin_out}, {23'd0, r_pin});
      chk("R9 model flags", {20'd0, flags}, {20'd0, r_fl});
      chk("R8 model srq", {23'd0, srq}, {23'd0, (r_fl[0] & r_ctl[19]) | (r_fl[1] & r_ctl[20]) |
          (r_ctl[21] & (r_ctl[22] ? r_fl[3] : r_fl[2]))});
      chk("R2 model cap1", cap1, r_c1);
      chk("R3 model cap2", cap2, r_c2);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [23:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr_all();
    flag_clr = 4'hF;
    @(negedge clk);
    flag_clr = 4'h0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog got=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cmp_on = 1'b1;
    chk("R1 reset pin_out", {23'd0, pin_out}, 24'd0);
    chk("R1 reset flags", {20'd0, flags}, 24'd0);
    chk("R1 reset srq", {23'd0, srq}, 24'd0);

    // R4 and R8: wrap-aware compare, one-shot, service request
    tb_a = 24'hFFFF00;
    wr(2'd0, 24'h000002 | (24'd1 << 19));
    wr(2'd1, 24'h000100);
    tick(3);
    chk("R4 no fire before wrap", {23'd0, flags[0]}, 24'd0);
    chk("R8 srq idle", {23'd0, srq}, 24'd0);
    tb_a = 24'h0000FF; tick(2);
    chk("R4 no fire one below", {23'd0, flags[0]}, 24'd0);
    tb_a = 24'h000105; tick(1);
    chk("R4 fire past value", {23'd0, flags[0]}, 24'd1);
    chk("R8 srq on enabled flag", {23'd0, srq}, 24'd1);
    clr_all(); tick(3);
    chk("R4 one shot after clear", {23'd0, flags[0]}, 24'd0);
    chk("R8 srq after clear", {23'd0, srq}, 24'd0);

    // R5: equal-only
    wr(2'd0, 24'h000002 | (24'd1 << 7));
    tb_a = 24'h000020;
    wr(2'd1, 24'h000010);
    tick(2);
    chk("R5 equal-only ignores greater", {23'd0, flags[0]}, 24'd0);
    tb_a = 24'h000010; tick(1);
    chk("R5 equal-only fires on equal", {23'd0, flags[0]}, 24'd1);
    clr_all();

    // R11: no firing in mode 1, no pin action in a timeout mode
    wr(2'd0, 24'h000001 | (24'd1 << 13));
    tb_a = 24'h000040;
    wr(2'd1, 24'h000030);
    tick(3);
    chk("R11 mode 1 match ignored", {23'd0, flags[0]}, 24'd0);
    wr(2'd0, 24'h000002 | (24'd1 << 13));
    tick(1);
    chk("R11 timeout fires", {23'd0, flags[0]}, 24'd1);
    chk("R11 timeout leaves pin", {23'd0, pin_out}, 24'd0);
    clr_all();

    // R6: pin actions, match 2 priority
    wr(2'd0, 24'h000006 | (24'd1 << 13) | (24'd2 << 15));
    tb_a = 24'h000040;
    wr(2'd1, 24'h000050);
    wr(2'd2, 24'h000050);
    tick(1);
    chk("R6 not yet", {22'd0, flags[1:0]}, 24'd0);
    tb_a = 24'h000050; tick(1);
    chk("R6 both fired", {22'd0, flags[1:0]}, 24'd3);
    chk("R6 match2 low wins", {23'd0, pin_out}, 24'd0);
    tb_a = 24'h000060;
    wr(2'd1, 24'h000060);
    tick(1);
    chk("R6 match1 drive high", {23'd0, pin_out}, 24'd1);
    clr_all();

    // R7: match on A captures B
    wr(2'd0, 24'h000002 | (24'd1 << 23) | (24'd1 << 12));
    tb_b = 24'h123456; tb_a = 24'h000070;
    wr(2'd1, 24'h000070);
    tick(1);
    chk("R7 cross capture value", cap2, 24'h123456);
    chk("R7 cross capture flag", {23'd0, flags[3]}, 24'd1);
    clr_all();

    // R2: falling-only edge on base B
    wr(2'd0, 24'h000001 | (24'd2 << 3) | (24'd1 << 11));
    tb_b = 24'h000DEF; pin_in = 1'b1; tick(1);
    chk("R2 rising ignored", cap1, 24'h000000);
    tb_b = 24'h000ABC; pin_in = 1'b0; tick(1);
    chk("R2 falling captured", cap1, 24'h000ABC);
    chk("R2 capture flag", {23'd0, flags[2]}, 24'd1);
    clr_all();

    // R3: double capture alternation
    wr(2'd0, 24'h000004 | (24'd1 << 3) | (24'd2 << 5));
    tb_a = 24'h000111; pin_in = 1'b1; tick(1);
    chk("R3 first edge to cap1", cap1, 24'h000111);
    tb_a = 24'h000222; pin_in = 1'b0; tick(1);
    chk("R3 second edge to cap2", cap2, 24'h000222);
    chk("R3 cap1 kept", cap1, 24'h000111);
    tb_a = 24'h000333; pin_in = 1'b1; tick(1);
    chk("R3 third edge to cap1", cap1, 24'h000333);
    clr_all();

    // R10: input-dependent output, toggle one clock later
    wr(2'd0, 24'h000007 | (24'd1 << 3) | (24'd3 << 17));
    pin_in = 1'b0; tick(1);
    tb_a = 24'h000444; pin_in = 1'b1; tick(1);
    chk("R10 capture on edge", cap1, 24'h000444);
    chk("R10 pin not yet", {23'd0, pin_out}, 24'd1);
    tick(1);
    chk("R10 pin toggled", {23'd0, pin_out}, 24'd0);
    clr_all();

    // random phase checked by the model
    for (int i = 0; i < 4000; i++) begin
      tb_a = tb_a + 24'($urandom_range(0, 3));
      tb_b = tb_b + 24'($urandom_range(1, 5));
      if ($urandom_range(0, 199) == 0) tb_a = 24'hFFFFF0;
      if ($urandom_range(0, 3) == 0) pin_in = !pin_in;
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_sel = 2'($urandom_range(0, 3));
      if (cfg_sel == 2'd0) cfg_data = 24'($urandom());
      else cfg_data = ($urandom_range(0, 1) ? tb_a : tb_b) + 24'($urandom_range(0, 40)) - 24'd8;
      flag_clr = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      tick(1);
    end
    cfg_we = 1'b0; flag_clr = 4'h0;
    tick(2);
    summary();
    $finish;
  end
endmodule